// File: doc/BRIEF.md
# Image Sensor Serial Configuration Engine

This block sits between a host processor and a CMOS image sensor. The host never builds serial bit streams. It presents a small operating-mode code with a one-cycle request strobe. The engine keeps the sensor's complete 159-bit control word in local registers. On a request it rewrites the exposure-time, gain and slope-count fields of that word from an internal mode table. It then sends the whole word to the sensor in one chip-select frame.

The serial clock comes from the system clock through a divider. The host can reprogram the divider while the engine is idle. The host sees only a busy flag and a one-cycle done pulse, so it is never held up by the slower serial rate. A request that arrives while a frame is on the wire is held and carried out once that frame ends. If several such requests arrive, the newest mode code is used. All bits of the word that the mode table does not cover keep the value they had at reset.

Top module: `sensor_cfg_engine`

## Requirements
- R1: While reset is low, and in the first cycle after it, cs_n is 1, sclk is 0, mosi is 0, busy is 0 and done is 0. The divider holds the value 8.
- R2: A frame sends the word most significant bit first, from bit 158 down to bit 0, with 159 rising sclk edges. mosi changes only in the cycle that sclk falls, or at frame start, so it is stable at every rising edge.
- R3: Each mode writes three fields: exposure in bits 111..100, gain in bits 47..40 and slope count in bits 10..8. The values are: mode 0 = 0x800/0x10/1, mode 1 = 0x200/0x20/2, mode 2 = 0x080/0x40/3, mode 3 = 0x020/0x80/4.
- R4: sclk is low whenever no frame is active. Each sclk half-period lasts D system clocks, where D is the divider value, and a divider value of 0 behaves as 1.
- R5: cs_n goes low two cycles after the request is sampled when the engine is idle. It stays low for exactly 319·D cycles, which means it rises D cycles after the last falling sclk edge.
- R6: done is high for exactly one cycle, which is the first cycle in which cs_n is high again.
- R7: busy is high from the cycle after a request is sampled until the cycle done is high. In that done cycle busy is low, unless a further request is waiting.
- R8: A request sampled while the engine is busy is latched, and the newest mode code wins. The next frame starts with cs_n high for two cycles after the current frame's done.
- R9: A divider write (div_we) is taken only while busy is low. A write while busy is ignored, and later frames keep the old rate.
- R10: Bits of the word outside the three fields of R3 are sent with their reset value in every frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | One-cycle mode request strobe |
| mode | input | 2 | Requested mode code |
| div_we | input | 1 | Divider write strobe |
| div_val | input | 8 | New sclk half-period in system clocks |
| busy | output | 1 | Request pending or frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the sensor |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bench builds the engine with its default widths and field positions. It overrides only the reset word, using an alternating pattern so that any bit sent out of order, or any field written in the wrong place, shows up as a visible difference. It drives the divider at its reset value 8 and also at 0, 1 and 3. Divider values of 0 and 1 keep each 159-bit frame to about 320 cycles, which leaves room for back-to-back frames, overlapping requests and a divider write made during a frame. A reference model is compared with the serial pins every cycle, and the bits collected on rising sclk edges are checked against the expected word.

// File: rtl/cfg_pkg.sv
// Package cfg_pkg
// Shared widths and types for the sensor configuration engine.
// Assumes a four-entry mode table; the field widths are set here.
package cfg_pkg;
    parameter int MODE_W  = 2;
    parameter int EXP_W   = 12;
    parameter int GAIN_W  = 8;
    parameter int SLOPE_W = 3;

    typedef struct packed {
        logic [EXP_W-1:0]   exposure;
        logic [GAIN_W-1:0]  gain;
        logic [SLOPE_W-1:0] slopes;
    } mode_fields_t;

    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_SHIFT = 2'd1,
        SH_TAIL  = 2'd2
    } shift_state_t;
endpackage

// File: rtl/cfg_mode_table.sv
// Module cfg_mode_table
// Combinational lookup that maps a mode code to the exposure, gain and
// slope-count values written into the control word.
// Assumes: codes outside the table fall back to the mode 0 entry.
module cfg_mode_table
    import cfg_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output mode_fields_t      fields
);
    // Select the field set for the requested mode
    always_comb begin
        case (mode)
            MODE_W'(1): fields = '{exposure: EXP_W'(12'h200), gain: GAIN_W'(8'h20), slopes: SLOPE_W'(2)};
            MODE_W'(2): fields = '{exposure: EXP_W'(12'h080), gain: GAIN_W'(8'h40), slopes: SLOPE_W'(3)};
            MODE_W'(3): fields = '{exposure: EXP_W'(12'h020), gain: GAIN_W'(8'h80), slopes: SLOPE_W'(4)};
            default:    fields = '{exposure: EXP_W'(12'h800), gain: GAIN_W'(8'h10), slopes: SLOPE_W'(1)};
        endcase
    end
endmodule

// File: rtl/cfg_word_reg.sv
// Module cfg_word_reg
// Holds the full sensor control word. On wr_en it overwrites the three
// mode fields and leaves every other bit unchanged.
// Assumes: the field positions fit inside WORD_W and do not overlap.
module cfg_word_reg
    import cfg_pkg::*;
#(
    parameter int               WORD_W    = 159,
    parameter logic [WORD_W-1:0] INIT_WORD = '0,
    parameter int               EXP_LSB   = 100,
    parameter int               GAIN_LSB  = 40,
    parameter int               SLOPE_LSB = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  mode_fields_t      fields,
    output logic [WORD_W-1:0] word
);
    // Load the reset word, then apply field edits on request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= INIT_WORD;
        end else if (wr_en) begin
            word[EXP_LSB   +: EXP_W]   <= fields.exposure;
            word[GAIN_LSB  +: GAIN_W]  <= fields.gain;
            word[SLOPE_LSB +: SLOPE_W] <= fields.slopes;
        end
    end
endmodule

// File: rtl/cfg_spi_shifter.sv
// Module cfg_spi_shifter
// Sends the word MSB first as one chip-select frame. sclk idles low and
// mosi changes on its falling edges. cs_n rises one half-period after the
// last falling edge, and done pulses in that same cycle.
// Assumes: word and half_div are held stable while active is high.
module cfg_spi_shifter
    import cfg_pkg::*;
#(
    parameter int WORD_W = 159,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DIV_W-1:0]  half_div,
    input  logic [WORD_W-1:0] word,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n,
    output logic              done,
    output logic              active
);
    localparam int IDX_W = $clog2(WORD_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

    shift_state_t      state;
    logic [DIV_W-1:0]  cnt;
    logic [DIV_W-1:0]  half_last;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  idx_next;
    logic              half_end;

    // Terminal count of one half-period; a zero divider acts as one
    always_comb begin
        half_last = (half_div == '0) ? '0 : half_div - DIV_W'(1);
        half_end  = (cnt == half_last);
        idx_next  = idx - IDX_W'(1);
    end

    assign active = (state != SH_IDLE);

    // Frame sequencer: clock generation, bit stepping and frame close
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SH_IDLE;
            cs_n  <= 1'b1;
            sclk  <= 1'b0;
            mosi  <= 1'b0;
            done  <= 1'b0;
            cnt   <= '0;
            idx   <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                SH_IDLE: begin
                    if (start) begin
                        state <= SH_SHIFT;
                        cs_n  <= 1'b0;
                        sclk  <= 1'b0;
                        cnt   <= '0;
                        idx   <= LAST_IDX;
                        mosi  <= word[LAST_IDX];
                    end
                end
                SH_SHIFT: begin
                    if (half_end) begin
                        cnt  <= '0;
                        sclk <= ~sclk;
                        if (sclk) begin
                            if (idx == '0) begin
                                state <= SH_TAIL;
                            end else begin
                                idx  <= idx_next;
                                mosi <= word[idx_next];
                            end
                        end
                    end else begin
                        cnt <= cnt + DIV_W'(1);
                    end
                end
                SH_TAIL: begin
                    if (half_end) begin
                        state <= SH_IDLE;
                        cs_n  <= 1'b1;
                        mosi  <= 1'b0;
                        done  <= 1'b1;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + DIV_W'(1);
                    end
                end
                default: state <= SH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sensor_cfg_engine.sv
// Module sensor_cfg_engine
// Top level. Latches host mode requests, edits the control word from the
// mode table while the serial port is idle, and then starts one frame.
// A request made during a frame waits, and the newest code wins.
// Assumes: req is a single-cycle strobe in the clk domain.
module sensor_cfg_engine
    import cfg_pkg::*;
#(
    parameter int                WORD_W    = 159,
    parameter int                DIV_W     = 8,
    parameter int                DIV_RESET = 8,
    parameter int                EXP_LSB   = 100,
    parameter int                GAIN_LSB  = 40,
    parameter int                SLOPE_LSB = 8,
    parameter logic [WORD_W-1:0] INIT_WORD = {{19{8'hA5}}, 7'h3C}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [MODE_W-1:0] mode,
    input  logic              div_we,
    input  logic [DIV_W-1:0]  div_val,
    output logic              busy,
    output logic              done,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n
);
    logic              pend;
    logic [MODE_W-1:0] pend_mode;
    logic              start_q;
    logic              edit;
    logic              sh_active;
    logic [DIV_W-1:0]  div_reg;
    logic [WORD_W-1:0] word;
    mode_fields_t      fields;

    assign edit = pend && !start_q && !sh_active;
    assign busy = pend || start_q || sh_active;

    // Hold the newest request until the serial port is free
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            pend_mode <= '0;
        end else if (req) begin
            pend      <= 1'b1;
            pend_mode <= mode;
        end else if (edit) begin
            pend <= 1'b0;
        end
    end

    // Start the frame the cycle after the word edit
    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= edit;
    end

    // Divider register, writable only while the engine is idle
    always_ff @(posedge clk) begin
        if (!rst_n)                div_reg <= DIV_W'(DIV_RESET);
        else if (div_we && !busy)  div_reg <= div_val;
    end

    cfg_mode_table u_table (
        .mode   (pend_mode),
        .fields (fields)
    );

    cfg_word_reg #(
        .WORD_W    (WORD_W),
        .INIT_WORD (INIT_WORD),
        .EXP_LSB   (EXP_LSB),
        .GAIN_LSB  (GAIN_LSB),
        .SLOPE_LSB (SLOPE_LSB)
    ) u_word (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (edit),
        .fields (fields),
        .word   (word)
    );

    cfg_spi_shifter #(
        .WORD_W (WORD_W),
        .DIV_W  (DIV_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_q),
        .half_div (div_reg),
        .word     (word),
        .sclk     (sclk),
        .mosi     (mosi),
        .cs_n     (cs_n),
        .done     (done),
        .active   (sh_active)
    );
endmodule

// File: rtl/cfg_engine_checker.sv
// Module cfg_engine_checker
// Port-level temporal properties of sensor_cfg_engine, bound to the top.
module cfg_engine_checker (
    input logic clk,
    input logic rst_n,
    input logic req,
    input logic busy,
    input logic done,
    input logic sclk,
    input logic mosi,
    input logic cs_n
);
    // R4: serial clock is low outside a frame
    p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R2: data does not move on a rising serial clock edge
    p_mosi_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(mosi));

    // R6: done marks the release of chip select
    p_done_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $rose(cs_n));

    // R6: done never lasts two cycles
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: busy covers the whole frame
    p_busy_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);

    // R7: an accepted request raises busy next cycle
    p_req_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> busy);
endmodule

bind sensor_cfg_engine cfg_engine_checker u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .busy  (busy),
    .done  (done),
    .sclk  (sclk),
    .mosi  (mosi),
    .cs_n  (cs_n)
);

// File: tb/sensor_cfg_engine_test.sv
module sensor_cfg_engine_test;
    localparam logic [158:0] TB_INIT = {{19{8'h5A}}, 7'h29};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0;
    logic [1:0] mode = '0;
    logic       div_we = 1'b0;
    logic [7:0] div_val = '0;
    logic       busy, done, sclk, mosi, cs_n;

    int n_chk = 0;
    int n_fail = 0;
    bit run_cmp = 0;

    always #5 clk = ~clk;

    sensor_cfg_engine #(.INIT_WORD(TB_INIT)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .mode(mode),
        .div_we(div_we), .div_val(div_val), .busy(busy), .done(done),
        .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Field values per mode as stated in R3
    function automatic logic [158:0] apply_mode(input logic [158:0] w, input int m);
        logic [11:0] e; logic [7:0] g; logic [2:0] s;
        case (m)
            1: begin e = 12'h200; g = 8'h20; s = 3'd2; end
            2: begin e = 12'h080; g = 8'h40; s = 3'd3; end
            3: begin e = 12'h020; g = 8'h80; s = 3'd4; end
            default: begin e = 12'h800; g = 8'h10; s = 3'd1; end
        endcase
        w[111:100] = e; w[47:40] = g; w[10:8] = s;
        return w;
    endfunction

    function automatic int eff_div(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // Behavioural reference model, advanced on each rising edge
    bit           m_pend, m_startq, m_active, m_done;
    int           m_pmode, m_div, m_d, t;
    logic [158:0] m_word;

    always @(posedge clk) begin
        bit o_busy, o_active, o_startq, o_pend;
        if (!rst_n) begin
            m_pend = 0; m_startq = 0; m_active = 0; m_done = 0;
            m_pmode = 0; m_div = 8; m_d = 8; t = 0; m_word = TB_INIT;
        end else begin
            o_pend = m_pend; o_startq = m_startq; o_active = m_active;
            o_busy = m_pend || m_startq || m_active;
            m_done = 0;
            if (m_active) begin
                t++;
                if (t == 319 * m_d) begin m_active = 0; m_done = 1; end
            end
            if (o_startq) begin m_active = 1; t = 0; m_startq = 0; end
            if (!o_active && o_pend && !o_startq) begin
                m_word = apply_mode(m_word, m_pmode);
                m_pend = 0; m_startq = 1; m_d = eff_div(m_div);
            end
            if (req) begin m_pend = 1; m_pmode = int'(mode); end
            if (div_we && !o_busy) m_div = int'(div_val);
        end
    end

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (run_cmp) begin
            bit e_sclk, e_mosi;
            e_sclk = m_active && (t < 318 * m_d) && (((t / m_d) % 2) == 1);
            e_mosi = !m_active ? 1'b0 :
                     (t < 318 * m_d) ? m_word[158 - t / (2 * m_d)] : m_word[0];
            chk(cs_n == !m_active, "R5 cs_n", cs_n, !m_active);
            chk(sclk == e_sclk, "R4 sclk", sclk, e_sclk);
            chk(mosi == e_mosi, "R2 mosi", mosi, e_mosi);
            chk(busy == (m_pend || m_startq || m_active), "R7 busy", busy, m_pend || m_startq || m_active);
            chk(done == m_done, "R6 done", done, m_done);
        end
    end

    // Frame capture: bits on rising sclk, checked against queued expectations
    logic [158:0] exp_q[$];
    int           expd_q[$];
    logic [158:0] cap;
    int           cap_n, cs_cnt;
    bit           p_sclk = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            cap_n = 0; cs_cnt = 0; p_sclk = 0;
        end else begin
            if (sclk && !p_sclk) begin cap = {cap[157:0], mosi}; cap_n++; end
            p_sclk = sclk;
            if (!cs_n) cs_cnt++;
            if (done) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R8 unexpected frame", 1, 0);
                end else begin
                    logic [158:0] ew; int ed;
                    ew = exp_q.pop_front(); ed = expd_q.pop_front();
                    chk(cap == ew, "R3/R10 word", cap[111:100], ew[111:100]);
                    chk(cap_n == 159, "R2 bit count", cap_n, 159);
                    chk(cs_cnt == 319 * ed, "R5/R9 cs length", cs_cnt, 319 * ed);
                end
                cap_n = 0; cs_cnt = 0;
            end
        end
    end

    logic [158:0] tb_word = TB_INIT;

    task automatic do_req(input int m);
        @(negedge clk); req = 1; mode = 2'(m);
        @(negedge clk); req = 0;
    endtask

    task automatic set_div(input int v);
        @(negedge clk); div_we = 1; div_val = 8'(v);
        @(negedge clk); div_we = 0;
    endtask

    task automatic expect_frame(input int m, input int d);
        tb_word = apply_mode(tb_word, m);
        exp_q.push_back(tb_word); expd_q.push_back(d);
    endtask

    task automatic wait_done;
        do @(negedge clk); while (!done);
        @(negedge clk);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(cs_n == 1 && sclk == 0 && mosi == 0 && busy == 0 && done == 0,
            "R1 reset outputs", {cs_n, sclk, mosi, busy, done}, 5'b10000);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        chk(cs_n == 1 && busy == 0 && done == 0, "R1 after reset", {cs_n, busy, done}, 3'b100);
        run_cmp = 1;

        // R9/R5: default divider of 8
        expect_frame(1, 8); do_req(1); wait_done();

        // R3: fast frames under several modes
        set_div(1);
        expect_frame(0, 1); do_req(0); wait_done();

        // R8: requests during a frame; R9: divider write while busy ignored
        expect_frame(2, 1); do_req(2);
        do @(negedge clk); while (cs_n);
        do_req(3); do_req(1);
        set_div(3);
        expect_frame(1, 1);
        wait_done(); wait_done();
        expect_frame(0, 1); do_req(0); wait_done();

        // R4: divider zero acts as one
        set_div(0);
        expect_frame(3, 1); do_req(3); wait_done();

        // R4: divider of three
        set_div(3);
        expect_frame(2, 3); do_req(2); wait_done();

        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R8 all frames seen", exp_q.size(), 0);
        chk(busy == 0 && cs_n == 1, "R7 idle at end", {busy, cs_n}, 2'b01);
        finish_run();
    end
endmodule